// File: doc/BRIEF.md
# Link Error Aggregation and Reporting Unit

This unit sits on the receive side of a serial video link. It merges three independent error sources into one active-low alarm pin, `err_no`. The first source is a control-channel status byte that the far end returns after the channel is closed. The second is a saturating 16-bit count of video parity errors, checked against a programmable 16-bit threshold. The third is a level flag from a PRBS checker.

Each source has its own clear rule. The UART status register clears when it is read. The parity alarm drops when a new video phase begins. An optional auto-reset mode clears the status register, the parity count and the parity alarm each time a control channel ends. PRBS errors are never cleared by the unit, because it only mirrors that flag.

Software reaches the unit through a small byte-wide register port with a one-cycle read latency. The port holds the control bits, the threshold bytes, the count bytes and the UART status.

Top module: `lerr_report`

## Requirements
- R1: After reset `err_no` is 1, and registers 1, 8, 9, 10, 11 and 13 all read 0.
- R2: A byte on `efrm_data_i` with `efrm_valid_i` is accepted only after a `cc_end_i` pulse, and at most once before the next `cc_start_i` pulse. Its bits [3:0] are ORed into register 13. Bits [7:4] and frames outside that window are ignored.
- R3: `err_no` is 0 while `lock_i` is 1 and any bit of register 13 is 1. While `lock_i` is 0, register 13 does not pull `err_no` low.
- R4: A read of address 13 returns the status in bits [3:0] and clears it. If UART status was the only cause, `err_no` returns to 1 in the cycle after the read.
- R5: With control bit 3 (register 1) set, each cycle with `par_err_i` high adds one to the parity count. With the bit clear, `par_err_i` has no effect.
- R6: The parity count saturates at 0xFFFF.
- R7: A read of address 10 returns count bits [7:0] and clears the count. In the same cycle it latches count bits [15:8], which a later read of address 11 returns.
- R8: When an increment leaves the count greater than or equal to the threshold {reg 9, reg 8}, a parity alarm sets and drives `err_no` to 0. A `vid_start_i` pulse clears the alarm.
- R9: With control bit 5 clear, the parity count is kept across `cc_start_i`/`cc_end_i` pulses until it is read.
- R10: With control bit 5 set, a `cc_end_i` pulse clears register 13, the parity count and the parity alarm.
- R11: `prbs_err_i` high drives `err_no` to 0 regardless of lock, reads or auto-reset.
- R12: Read data appears on `reg_rdata_o` one cycle after `reg_re_i`. Writes take effect only at addresses 1, 8 and 9. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Link locked; gates UART error reporting |
| cc_start_i | input | 1 | Control channel opens (pulse) |
| cc_end_i | input | 1 | Control channel closed by end frame (pulse) |
| vid_start_i | input | 1 | Video phase begins (pulse) |
| par_err_i | input | 1 | One video parity error this cycle |
| prbs_err_i | input | 1 | PRBS checker error level |
| efrm_valid_i | input | 1 | Error-frame byte valid |
| efrm_data_i | input | 8 | Error-frame byte |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, one cycle after read |
| err_no | output | 1 | Aggregated error, active low |

## Verification
Several properties are checked on every cycle:
- the status register clears on a read and on auto-reset;
- the parity count either steps by one or holds at saturation;
- the alarm clears on a video-phase start;
- `err_no` stays high when lock is low and no other cause is present.

Only the bench scenarios can show the rest:
- the frame acceptance window across channel open and close;
- the threshold crossing at the exact count;
- the high-byte latch seen through a later read;
- the rule that PRBS errors survive auto-reset.

// File: rtl/lerr_pkg.sv
package lerr_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int STAT_W   = 4;
  localparam int CNT_W    = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_THR_LO = 4'd8;
  localparam logic [ADDR_W-1:0] A_THR_HI = 4'd9;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd10;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd11;
  localparam logic [ADDR_W-1:0] A_USTAT  = 4'd13;

  localparam int CTRL_PAR_EN = 3;
  localparam int CTRL_AUTO   = 5;
endpackage

// File: rtl/lerr_cfg_regs.sv
module lerr_cfg_regs
  import lerr_pkg::*;
#(
  parameter int NBYTES = CNT_W / DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        ctrl_o,
  output logic [NBYTES*DATA_W-1:0] thr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ctrl_o <= '0;
    else if (we_i && addr_i == A_CTRL)  ctrl_o <= wdata_i;
  end

  // threshold bytes sit at consecutive addresses, low byte first
  for (genvar b = 0; b < NBYTES; b++) begin : g_thr
    localparam logic [ADDR_W-1:0] BA = A_THR_LO + ADDR_W'(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  thr_o[b*DATA_W +: DATA_W] <= '0;
      else if (we_i && addr_i == BA) thr_o[b*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  a_r12_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL) |=> ctrl_o == $past(wdata_i));
endmodule

// File: rtl/lerr_uart_stat.sv
module lerr_uart_stat
  import lerr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cc_start_i,
  input  logic              cc_end_i,
  input  logic              frm_valid_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              rd_clr_i,
  input  logic              auto_clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic wait_q;
  logic load;
  logic [STAT_W-1:0] base;

  assign load = frm_valid_i && wait_q;
  assign base = (rd_clr_i || auto_clr_i) ? '0 : stat_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wait_q <= 1'b0;
    else if (cc_end_i)   wait_q <= 1'b1;
    else if (cc_start_i || load) wait_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= base | (load ? frm_data_i[STAT_W-1:0] : '0);
  end

  a_r4_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !frm_valid_i) |=> stat_o == '0);
  a_r10_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_clr_i && !frm_valid_i) |=> stat_o == '0);
  a_r2_no_frame_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> (stat_o & ~$past(stat_o)) == '0);
endmodule

// File: rtl/lerr_par_count.sv
module lerr_par_count
  import lerr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             rd_clr_i,
  input  logic             auto_clr_i,
  input  logic             vid_start_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DATA_W-1:0] hi_latch_o,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] base, cnt_nx;
  logic             set_alarm;

  assign base      = (rd_clr_i || auto_clr_i) ? '0 : cnt_o;
  assign cnt_nx    = (inc_i && base != CNT_MAX) ? base + 1'b1 : base;
  assign set_alarm = inc_i && (cnt_nx >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_latch_o <= '0;
    else if (rd_clr_i) hi_latch_o <= cnt_o[CNT_W-1 -: DATA_W];
  end

  // a new error outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       alarm_o <= 1'b0;
    else if (set_alarm)                alarm_o <= 1'b1;
    else if (vid_start_i || auto_clr_i) alarm_o <= 1'b0;
  end

  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !rd_clr_i && !auto_clr_i) |=> cnt_o == CNT_MAX);
  a_r5_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !rd_clr_i && !auto_clr_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !rd_clr_i && !auto_clr_i) |=> $stable(cnt_o));
  a_r8_vid_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_start_i && !inc_i) |=> !alarm_o);
endmodule

// File: rtl/lerr_report.sv
module lerr_report
  import lerr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              cc_start_i,
  input  logic              cc_end_i,
  input  logic              vid_start_i,
  input  logic              par_err_i,
  input  logic              prbs_err_i,
  input  logic              efrm_valid_i,
  input  logic [7:0]        efrm_data_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              err_no
);
  logic [DATA_W-1:0] ctrl;
  logic [CNT_W-1:0]  thr, cnt;
  logic [DATA_W-1:0] hi_latch;
  logic [STAT_W-1:0] ustat;
  logic              alarm, auto_clr, rd_lo, rd_us, uart_cause;

  assign auto_clr = cc_end_i && ctrl[CTRL_AUTO];
  assign rd_lo    = reg_re_i && reg_addr_i == A_CNT_LO;
  assign rd_us    = reg_re_i && reg_addr_i == A_USTAT;

  lerr_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl), .thr_o(thr)
  );

  lerr_uart_stat u_ust (
    .clk_i, .rst_ni,
    .cc_start_i, .cc_end_i,
    .frm_valid_i(efrm_valid_i), .frm_data_i(efrm_data_i),
    .rd_clr_i(rd_us), .auto_clr_i(auto_clr),
    .stat_o(ustat)
  );

  lerr_par_count u_par (
    .clk_i, .rst_ni,
    .inc_i(par_err_i && ctrl[CTRL_PAR_EN]),
    .rd_clr_i(rd_lo), .auto_clr_i(auto_clr), .vid_start_i,
    .thr_i(thr), .cnt_o(cnt), .hi_latch_o(hi_latch), .alarm_o(alarm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else if (reg_re_i) begin
      unique case (reg_addr_i)
        A_CTRL:   reg_rdata_o <= ctrl;
        A_THR_LO: reg_rdata_o <= thr[DATA_W-1:0];
        A_THR_HI: reg_rdata_o <= thr[CNT_W-1 -: DATA_W];
        A_CNT_LO: reg_rdata_o <= cnt[DATA_W-1:0];
        A_CNT_HI: reg_rdata_o <= hi_latch;
        A_USTAT:  reg_rdata_o <= {{(DATA_W-STAT_W){1'b0}}, ustat};
        default:  reg_rdata_o <= '0;
      endcase
    end
  end

  assign uart_cause = lock_i && (ustat != '0);
  assign err_no     = !(uart_cause || alarm || prbs_err_i);

  a_r3_lock_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && !alarm && !prbs_err_i) |-> err_no);
  a_r11_prbs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prbs_err_i |-> !err_no);
  a_r8_alarm_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm |-> !err_no);
  a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == 4'd3) |=> reg_rdata_o == '0);
endmodule

// File: tb/sim_lerr_report.sv
module sim_lerr_report;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lock = 1'b1, cc_s = 1'b0, cc_e = 1'b0, vid = 1'b0, par = 1'b0, prbs = 1'b0;
  logic fv = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] fd = '0, wd = '0, rd;
  logic [3:0] ad = '0;
  logic err_n;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  lerr_report u0 (
    .clk_i(clk), .rst_ni(rst_n), .lock_i(lock), .cc_start_i(cc_s), .cc_end_i(cc_e),
    .vid_start_i(vid), .par_err_i(par), .prbs_err_i(prbs), .efrm_valid_i(fv),
    .efrm_data_i(fd), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(ad),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .err_no(err_n)
  );

  localparam logic [3:0] WR = 1, RD = 2, PAR = 3, CCE = 4, CCS = 5, FRM = 6, VID = 7, ERR = 8;
  // {op, addr, data, expected, requirement}
  localparam int NV = 42;
  localparam logic [31:0] VEC [NV] = '{
    {WR, 4'd1, 8'h08, 8'h00, 8'd12},
    {RD, 4'd1, 8'h00, 8'h08, 8'd12},  // R12
    {WR, 4'd8, 8'h03, 8'h00, 8'd12},
    {WR, 4'd9, 8'h00, 8'h00, 8'd12},
    {RD, 4'd8, 8'h00, 8'h03, 8'd12},
    {RD, 4'd9, 8'h00, 8'h00, 8'd12},
    {PAR,4'd0, 8'd2,  8'h00, 8'd5},
    {ERR,4'd0, 8'h00, 8'h01, 8'd8},   // R8 below threshold
    {PAR,4'd0, 8'd1,  8'h00, 8'd5},
    {ERR,4'd0, 8'h00, 8'h00, 8'd8},   // R8 reached
    {VID,4'd0, 8'h00, 8'h00, 8'd8},
    {ERR,4'd0, 8'h00, 8'h01, 8'd8},   // R8 cleared by video start
    {CCS,4'd0, 8'h00, 8'h00, 8'd9},
    {CCE,4'd0, 8'h00, 8'h00, 8'd9},
    {RD, 4'd10,8'h00, 8'h03, 8'd9},   // R9 kept across channel
    {RD, 4'd11,8'h00, 8'h00, 8'd7},   // R7
    {RD, 4'd10,8'h00, 8'h00, 8'd7},
    {CCS,4'd0, 8'h00, 8'h00, 8'd2},
    {CCE,4'd0, 8'h00, 8'h00, 8'd2},
    {FRM,4'd0, 8'hF5, 8'h00, 8'd2},
    {ERR,4'd0, 8'h00, 8'h00, 8'd3},   // R3
    {RD, 4'd13,8'h00, 8'h05, 8'd4},   // R4, R2 upper bits dropped
    {ERR,4'd0, 8'h00, 8'h01, 8'd4},
    {FRM,4'd0, 8'h02, 8'h00, 8'd2},
    {RD, 4'd13,8'h00, 8'h00, 8'd2},   // R2 outside window
    {WR, 4'd1, 8'h00, 8'h00, 8'd5},
    {PAR,4'd0, 8'd4,  8'h00, 8'd5},
    {RD, 4'd10,8'h00, 8'h00, 8'd5},   // R5 disabled
    {WR, 4'd3, 8'h55, 8'h00, 8'd12},
    {RD, 4'd3, 8'h00, 8'h00, 8'd12},  // R12 unmapped
    {WR, 4'd1, 8'h28, 8'h00, 8'd10},
    {PAR,4'd0, 8'd5,  8'h00, 8'd10},
    {ERR,4'd0, 8'h00, 8'h00, 8'd8},
    {CCS,4'd0, 8'h00, 8'h00, 8'd10},
    {CCE,4'd0, 8'h00, 8'h00, 8'd10},
    {ERR,4'd0, 8'h00, 8'h01, 8'd10},  // R10 alarm cleared
    {FRM,4'd0, 8'h01, 8'h00, 8'd2},
    {ERR,4'd0, 8'h00, 8'h00, 8'd2},
    {CCS,4'd0, 8'h00, 8'h00, 8'd10},
    {CCE,4'd0, 8'h00, 8'h00, 8'd10},
    {ERR,4'd0, 8'h00, 8'h01, 8'd10},  // R10 status cleared
    {RD, 4'd10,8'h00, 8'h00, 8'd10}
  };

  task automatic check(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_cc(input bit start);
    @(negedge clk); if (start) cc_s = 1'b1; else cc_e = 1'b1;
    @(negedge clk); cc_s = 1'b0; cc_e = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; ad = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input int req);
    @(negedge clk); re = 1'b1; ad = a;
    @(negedge clk); re = 1'b0;
    check(rd == e, req, rd, e);
  endtask

  task automatic par_n(input int n);
    @(negedge clk); par = 1'b1;
    repeat (n) @(negedge clk);
    par = 1'b0;
  endtask

  task automatic frame(input logic [7:0] d);
    @(negedge clk); fv = 1'b1; fd = d;
    @(negedge clk); fv = 1'b0;
  endtask

  task automatic err_chk(input logic e, input int req);
    @(negedge clk);
    check(err_n == e, req, err_n, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    err_chk(1'b1, 1);
    rd_chk(4'd1, 8'h00, 1);
    rd_chk(4'd8, 8'h00, 1);
    rd_chk(4'd9, 8'h00, 1);
    rd_chk(4'd10, 8'h00, 1);
    rd_chk(4'd11, 8'h00, 1);
    rd_chk(4'd13, 8'h00, 1);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, a;
      logic [7:0] d, e, q;
      {op, a, d, e, q} = VEC[i];
      case (op)
        WR:  wr(a, d);
        RD:  rd_chk(a, e, int'(q));
        PAR: par_n(int'(d));
        CCE: pulse_cc(1'b0);
        CCS: pulse_cc(1'b1);
        FRM: frame(d);
        VID: begin @(negedge clk); vid = 1'b1; @(negedge clk); vid = 1'b0; end
        ERR: err_chk(e[0], int'(q));
        default: ;
      endcase
    end

    // R3: lock low hides UART status
    pulse_cc(1'b1); pulse_cc(1'b0);
    frame(8'h08);
    lock = 1'b0;
    err_chk(1'b1, 3);
    lock = 1'b1;
    err_chk(1'b0, 3);
    rd_chk(4'd13, 8'h08, 4);

    // R11: PRBS survives auto-reset
    prbs = 1'b1;
    err_chk(1'b0, 11);
    pulse_cc(1'b1); pulse_cc(1'b0);
    err_chk(1'b0, 11);
    prbs = 1'b0;
    err_chk(1'b1, 11);

    // R6: saturation, high byte latch
    wr(4'd1, 8'h08);
    wr(4'd8, 8'hFF);
    wr(4'd9, 8'hFF);
    par_n(65537);
    err_chk(1'b0, 6);
    rd_chk(4'd10, 8'hFF, 6);
    rd_chk(4'd11, 8'hFF, 7);
    rd_chk(4'd10, 8'h00, 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule